// File: doc/BRIEF.md
# SDRAM Read Burst Sequencer

This block sits behind an SDRAM command scheduler and expands a single read command into the column addresses of a burst, one per clock. It also marks the cycles in which the memory drives the data bus and the cycles in which read data is valid, both delayed by a programmable CAS latency.

On each read command the block captures a 9-bit starting column and three mode fields. The length field picks 2, 4 or 8 beats, or an open-ended full-page burst. The order bit picks sequential or interleaved ordering. The latency bit picks 2 or 3 clocks.

Fixed-length bursts never leave the aligned block that holds the starting column. Full-page bursts count upward through the whole page, wrap at its end, and run until a stop input or a new read arrives. Interleaved order with full-page length is illegal. Such a command is rejected and reported.

Top module: `sdram_rd_burst_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `col_valid`, `dq_drive`, `dq_valid` and `mode_err` are all 0.
- R2: Encodings are as follows. `rd_len`: 00 gives 2 beats, 01 gives 4, 10 gives 8, 11 gives full page. `rd_ilv`: 0 gives sequential, 1 gives interleaved. `rd_cl3`: 0 gives latency 2, 1 gives latency 3. When a legal read is registered at edge n, `col_valid` is 1 and `col_addr` equals the starting column in the cycle that follows edge n.
- R3: In sequential mode with length L of 2, 4 or 8, beat k keeps the starting column's bits above log2(L). Its low log2(L) bits are (start + k) mod L.
- R4: In interleaved mode with length L of 2, 4 or 8, beat k keeps the starting column's bits above log2(L). Its low log2(L) bits are the starting low bits XOR k.
- R5: For length L of 2, 4 or 8, `col_valid` is high for exactly L consecutive cycles and then falls, unless the burst is stopped or restarted first.
- R6: A full-page burst steps the column up by one each cycle and wraps from 511 to 0. It continues until `burst_stop` is sampled high at an edge. `col_valid` is 0 in the cycle after that edge.
- R7: A read registered while a burst is active ends that burst. The new sequence starts in the next cycle, using the new column and new mode.
- R8: A read with `rd_len`=11 and `rd_ilv`=1 is rejected. In the next cycle `mode_err` is 1 for one cycle and `col_valid` is 0, and any burst in progress ends.
- R9: With latency m, each cycle in which `col_valid` is high causes `dq_valid` to be high exactly m cycles later. A burst of L beats that starts at edge n gives `dq_valid` in the cycles after edges n+m through n+m+L-1.
- R10: `dq_drive` is high from the cycle after edge n+m-1 through the last cycle in which `dq_valid` is high. It therefore leads the valid window by one cycle.
- R11: Mode inputs are sampled only with the read command. Changing them during a burst affects neither the addresses nor the strobe timing of that burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_cmd | input | 1 | Read command, one cycle per command |
| rd_col | input | 9 | Starting column of the read |
| rd_len | input | 2 | Burst length code |
| rd_ilv | input | 1 | Burst order: 0 sequential, 1 interleaved |
| rd_cl3 | input | 1 | CAS latency: 0 gives 2 clocks, 1 gives 3 |
| burst_stop | input | 1 | Ends the current burst |
| col_valid | output | 1 | A column address is presented this cycle |
| col_addr | output | 9 | Column address of the current beat |
| dq_drive | output | 1 | Memory drives the data bus |
| dq_valid | output | 1 | Read data valid on the bus |
| mode_err | output | 1 | Illegal mode combination was rejected |

## Verification
A corrupted step counter or latched base shows up on `col_addr` in the very next beat. It appears as a column outside the aligned block, a broken sequential or XOR order, or a missed wrap at the page end. A wrong length compare moves the fall of `col_valid` away from beat L, which is visible L cycles after the command. A misplaced latency injection shifts `dq_valid` and `dq_drive` against the command edge by one cycle, and this shows at the first data beat, two or three cycles after the read.

// File: rtl/sdram_rd_pkg.sv
// Package: shared types for the read burst sequencer.
// Assumes a column width of 9 bits is chosen at the top; the types here are width-free.
package sdram_rd_pkg;

    // Burst length code as carried on the mode input.
    typedef enum logic [1:0] {
        LEN_2    = 2'b00,
        LEN_4    = 2'b01,
        LEN_8    = 2'b10,
        LEN_PAGE = 2'b11
    } burst_len_e;

    // Mode captured with a read command and held for its burst.
    typedef struct packed {
        burst_len_e len;
        logic       ilv;
        logic       cl3;
    } rd_mode_t;

endpackage

// File: rtl/burst_addr_gen.sv
// Module: burst_addr_gen
// Produces one column per cycle for a burst. It keeps the starting column and a
// beat counter, and forms each column from them, so a burst stays in its aligned
// block (fixed lengths) or runs across the page (full page) until killed.
// Assumes load and kill are never both wanted: load wins.
module burst_addr_gen
    import sdram_rd_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             kill,
    input  logic [COL_W-1:0] start_col,
    input  burst_len_e       len,
    input  logic             ilv,
    output logic             active,
    output logic [COL_W-1:0] col
);

    localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] step_q;
    logic [COL_W-1:0] mask_q;
    logic             ilv_q;
    logic             page_q;
    logic             active_q;
    logic [COL_W-1:0] mask_d;
    logic [COL_W-1:0] low_bits;

    // Purpose: map the length code onto the low-bit mask of the aligned block.
    always_comb begin
        unique case (len)
            LEN_2:   mask_d = COL_W'(1);
            LEN_4:   mask_d = COL_W'(3);
            LEN_8:   mask_d = COL_W'(7);
            default: mask_d = ALL_ONES;
        endcase
    end

    // Purpose: capture a burst on load, then advance or retire it once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            step_q   <= '0;
            mask_q   <= '0;
            ilv_q    <= 1'b0;
            page_q   <= 1'b0;
            active_q <= 1'b0;
        end else if (load) begin
            base_q   <= start_col;
            step_q   <= '0;
            mask_q   <= mask_d;
            ilv_q    <= ilv;
            page_q   <= (len == LEN_PAGE);
            active_q <= 1'b1;
        end else if (kill) begin
            active_q <= 1'b0;
        end else if (active_q) begin
            if (!page_q && step_q == mask_q) begin
                active_q <= 1'b0;
            end else begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    // Purpose: pick counting or XOR order for the low bits of the block.
    always_comb begin
        low_bits = ilv_q ? (base_q ^ step_q) : (base_q + step_q);
    end

    // Purpose: form the presented column from the block bits and the ordered low bits.
    always_comb begin
        if (page_q) begin
            col = base_q + step_q;
        end else begin
            col = (base_q & ~mask_q) | (low_bits & mask_q);
        end
    end

    assign active = active_q;

    // A fixed-length burst never leaves its aligned block (R3, R4).
    p_block_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && $past(active_q) && !$past(load) && !page_q)
        |-> ((col & ~mask_q) == ($past(col) & ~mask_q)));

    // A full-page burst advances by exactly one column per beat, wrapping (R6).
    p_page_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && $past(active_q) && !$past(load) && page_q)
        |-> (col == $past(col) + 1'b1));

    // A fixed burst never counts past its last beat (R5).
    p_len_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !page_q) |-> (step_q <= mask_q));

endmodule

// File: rtl/cas_delay_line.sv
// Module: cas_delay_line
// Delays each beat by the latency chosen for it. A beat enters the shared shift
// line at the stage that leaves exactly its latency to the output, so bursts with
// different latencies can follow each other. Drive is the output stage plus the
// stage before it.
// Assumes MAX_LAT = MIN_LAT + 1 and MIN_LAT >= 2.
module cas_delay_line #(
    parameter int MIN_LAT = 2,
    parameter int MAX_LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic beat,
    input  logic lat_sel,
    output logic valid_o,
    output logic drive_o
);

    localparam int LAT_W = $clog2(MAX_LAT + 1);
    localparam int LOW_STAGE = MAX_LAT - MIN_LAT + 1;

    logic [MAX_LAT:1] pipe_q;
    logic [LAT_W-1:0] lat;

    // Purpose: turn the select bit into the latency value of this beat.
    always_comb begin
        lat = lat_sel ? LAT_W'(MAX_LAT) : LAT_W'(MIN_LAT);
    end

    // Purpose: build one stage per clock of the longest latency.
    for (genvar j = 1; j <= MAX_LAT; j++) begin : g_stage
        if (j == 1) begin : g_head
            // Purpose: first stage takes only beats that need the full latency.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q[j] <= 1'b0;
                else        pipe_q[j] <= beat && (lat == LAT_W'(MAX_LAT));
            end
        end else begin : g_body
            // Purpose: later stages shift and take beats whose latency starts here.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q[j] <= 1'b0;
                else        pipe_q[j] <= pipe_q[j-1] ||
                                         (beat && (lat == LAT_W'(MAX_LAT - j + 1)));
            end
        end
    end

    assign valid_o = pipe_q[MAX_LAT];
    assign drive_o = pipe_q[MAX_LAT] | pipe_q[MAX_LAT-1];

    // A short-latency beat reaches the output exactly MIN_LAT clocks later (R9).
    p_lat_short_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(beat && !lat_sel, 2) |-> valid_o);

    // A long-latency beat reaches the output exactly MAX_LAT clocks later (R9).
    p_lat_long_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(beat && lat_sel, 3) |-> valid_o);

    // The bus is already driven in the cycle before data first turns valid (R10).
    p_drive_lead_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> (drive_o && $past(drive_o)));

    // Only a single-step difference between latencies is supported.
    initial begin
        if (LOW_STAGE != 2) $error("cas_delay_line: MAX_LAT must be MIN_LAT + 1");
    end

endmodule

// File: rtl/sdram_rd_burst_seq.sv
// Module: sdram_rd_burst_seq (top)
// Accepts read commands, checks the mode combination, runs the column sequence
// and drives the latency-delayed bus strobes.
// Assumes rd_cmd is a single-cycle pulse per command; a new command overrides
// any burst in flight and takes priority over burst_stop.
module sdram_rd_burst_seq
    import sdram_rd_pkg::*;
#(
    parameter int COL_W   = 9,
    parameter int MIN_LAT = 2,
    parameter int MAX_LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_cmd,
    input  logic [COL_W-1:0] rd_col,
    input  logic [1:0]       rd_len,
    input  logic             rd_ilv,
    input  logic             rd_cl3,
    input  logic             burst_stop,
    output logic             col_valid,
    output logic [COL_W-1:0] col_addr,
    output logic             dq_drive,
    output logic             dq_valid,
    output logic             mode_err
);

    rd_mode_t mode_in;
    logic     legal;
    logic     load;
    logic     reject;
    logic     kill;
    logic     cl3_q;
    logic     err_q;

    // Purpose: gather the mode fields presented with the command.
    always_comb begin
        mode_in.len = burst_len_e'(rd_len);
        mode_in.ilv = rd_ilv;
        mode_in.cl3 = rd_cl3;
    end

    // Purpose: decide whether the command is accepted or rejected.
    always_comb begin
        legal  = !(mode_in.len == LEN_PAGE && mode_in.ilv);
        load   = rd_cmd && legal;
        reject = rd_cmd && !legal;
        kill   = burst_stop || reject;
    end

    // Purpose: hold the latency of the running burst and flag rejected commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cl3_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            err_q <= reject;
            if (load) cl3_q <= mode_in.cl3;
        end
    end

    burst_addr_gen #(
        .COL_W (COL_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .kill      (kill),
        .start_col (rd_col),
        .len       (mode_in.len),
        .ilv       (mode_in.ilv),
        .active    (col_valid),
        .col       (col_addr)
    );

    cas_delay_line #(
        .MIN_LAT (MIN_LAT),
        .MAX_LAT (MAX_LAT)
    ) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .beat    (col_valid),
        .lat_sel (cl3_q),
        .valid_o (dq_valid),
        .drive_o (dq_drive)
    );

    assign mode_err = err_q;

    // An accepted read presents its own column in the next cycle (R2, R7).
    p_first_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (col_valid && col_addr == $past(rd_col)));

    // A rejected read raises the error and leaves no burst running (R8).
    p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> (mode_err && !col_valid));

    // A stop with no command ends the burst at that edge (R6).
    p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_stop && !rd_cmd) |=> !col_valid);

endmodule

// File: tb/sdram_rd_burst_seq_test.sv
module sdram_rd_burst_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_cmd = 1'b0;
    logic [8:0] rd_col = '0;
    logic [1:0] rd_len = '0;
    logic       rd_ilv = 1'b0;
    logic       rd_cl3 = 1'b0;
    logic       burst_stop = 1'b0;
    logic       col_valid;
    logic [8:0] col_addr;
    logic       dq_drive;
    logic       dq_valid;
    logic       mode_err;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    sdram_rd_burst_seq uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_cmd     (rd_cmd),
        .rd_col     (rd_col),
        .rd_len     (rd_len),
        .rd_ilv     (rd_ilv),
        .rd_cl3     (rd_cl3),
        .burst_stop (burst_stop),
        .col_valid  (col_valid),
        .col_addr   (col_addr),
        .dq_drive   (dq_drive),
        .dq_valid   (dq_valid),
        .mode_err   (mode_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_col(int start, int len, bit ilv, int k);
        int off;
        int base;
        if (len == 512) return (start + k) % 512;
        off  = start % len;
        base = start - off;
        if (ilv) return base + (off ^ k);
        return base + ((off + k) % len);
    endfunction

    // Drive a command at a falling edge; returns at the falling edge after it is registered.
    task automatic issue(input int col, input int len_code, input bit ilv, input bit cl3);
        rd_cmd = 1'b1;
        rd_col = 9'(col);
        rd_len = 2'(len_code);
        rd_ilv = ilv;
        rd_cl3 = cl3;
        @(posedge clk);
        @(negedge clk);
        rd_cmd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Scenario: reset state (R1).
    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        check(!col_valid && !dq_valid && !dq_drive && !mode_err, "R1 in reset",
              {col_valid, dq_valid, dq_drive, mode_err}, 0);
        rst_n = 1'b1;
        idle(1);
        check(!col_valid && !dq_valid && !dq_drive && !mode_err, "R1 after release",
              {col_valid, dq_valid, dq_drive, mode_err}, 0);
    endtask

    // Scenario: one fixed-length burst, full window check (R2-R5, R9-R11).
    task automatic t_burst(input int col, input int len_code, input bit ilv, input bit cl3,
                           input bit scramble);
        int len = 2 << len_code;
        int m = cl3 ? 3 : 2;
        string areq = ilv ? "R4 order" : "R3 order";
        @(negedge clk);
        issue(col, len_code, ilv, cl3);
        if (scramble) begin
            rd_len = 2'(len_code ^ 1);
            rd_ilv = !ilv;
            rd_cl3 = !cl3;
            areq   = "R11 order";
        end
        for (int c = 0; c <= len + m + 1; c++) begin
            if (c > 0) @(negedge clk);
            check(col_valid == (c < len), scramble ? "R11 length" : "R5 length",
                  col_valid, (c < len));
            if (c == 0)
                check(col_addr == 9'(col), "R2 first column", col_addr, col);
            else if (c < len)
                check(col_addr == 9'(exp_col(col, len, ilv, c)), areq, col_addr,
                      exp_col(col, len, ilv, c));
            check(dq_valid == (c >= m && c <= m + len - 1), "R9 valid window",
                  dq_valid, (c >= m && c <= m + len - 1));
            check(dq_drive == (c >= m - 1 && c <= m + len - 1), "R10 drive window",
                  dq_drive, (c >= m - 1 && c <= m + len - 1));
        end
    endtask

    // Scenario: full page wrap and stop (R6, R9).
    task automatic t_page();
        @(negedge clk);
        issue(509, 3, 1'b0, 1'b0);
        for (int c = 0; c <= 5; c++) begin
            if (c > 0) @(negedge clk);
            check(col_valid && col_addr == 9'((509 + c) % 512), "R6 page wrap",
                  col_addr, (509 + c) % 512);
        end
        burst_stop = 1'b1;
        @(negedge clk);
        burst_stop = 1'b0;
        check(!col_valid, "R6 stop", col_valid, 0);
        check(dq_valid, "R9 page tail valid", dq_valid, 1);
        @(negedge clk);
        check(dq_valid, "R9 page last valid", dq_valid, 1);
        @(negedge clk);
        check(!dq_valid && !dq_drive, "R9 page drained", {dq_valid, dq_drive}, 0);
        idle(3);
    endtask

    // Scenario: a new read overrides a running burst (R7).
    task automatic t_restart();
        @(negedge clk);
        issue(16, 2, 1'b0, 1'b0);
        idle(2);
        check(col_addr == 9'd18, "R7 before restart", col_addr, 18);
        issue(35, 1, 1'b0, 1'b0);
        for (int c = 0; c < 5; c++) begin
            if (c > 0) @(negedge clk);
            if (c < 4)
                check(col_valid && col_addr == 9'(exp_col(35, 4, 1'b0, c)), "R7 new sequence",
                      col_addr, exp_col(35, 4, 1'b0, c));
            else
                check(!col_valid, "R7 new length", col_valid, 0);
        end
        idle(6);
    endtask

    // Scenario: illegal mode rejected and running burst ended (R8).
    task automatic t_reject();
        @(negedge clk);
        issue(64, 2, 1'b0, 1'b0);
        idle(1);
        issue(100, 3, 1'b1, 1'b0);
        check(mode_err && !col_valid, "R8 reject", {mode_err, col_valid}, 2);
        @(negedge clk);
        check(!mode_err && !col_valid, "R8 one-cycle flag", {mode_err, col_valid}, 0);
        idle(2);
        check(!dq_valid && !dq_drive, "R8 no data", {dq_valid, dq_drive}, 0);
        idle(4);
    endtask

    initial begin
        t_reset();
        t_burst(5, 2, 1'b0, 1'b0, 1'b0);
        t_burst(3, 2, 1'b1, 1'b0, 1'b0);
        t_burst(262, 1, 1'b0, 1'b1, 1'b0);
        t_burst(437, 1, 1'b1, 1'b1, 1'b0);
        t_burst(77, 0, 1'b0, 1'b0, 1'b0);
        t_burst(128, 0, 1'b1, 1'b1, 1'b0);
        t_burst(174, 2, 1'b0, 1'b0, 1'b1);
        t_page();
        t_restart();
        t_reject();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule